// File: doc/BRIEF.md
# Ring-Fed Receive DMA Channel

This block moves received frames from a byte-wide receive stream into system memory. Software prepares a ring of two-word descriptors in memory. Each descriptor holds a control word and the address of a buffer. Software then programs the ring base and tells the channel how far into the ring it may go. The channel fetches descriptors one at a time and fills their buffers with frame bytes. When a frame ends, the channel writes a four-byte length/flags header at the start of the frame's first buffer. It then moves on to the next frame.

Every frame starts with a reserved four-byte header area. A software-chosen gap of empty bytes follows the header, and the payload comes after the gap. A long frame spills over into the following descriptors. When the ring runs out in the middle of a frame, a control bit picks what happens. With the bit set, the rest of the frame is thrown away and marked in its header. With the bit clear, the channel halts with an error code. Descriptors are never written back. Progress is reported only through a status word: current index, channel state, error code and the first descriptor of the frame in progress.

Top module: `rxring_dma`

## Requirements
- R1: After reset, or while control bit 0 (enable) is clear, the status word reads 0 and rx_ready, desc_rd_req and mem_wr_en stay low. Clearing enable from any state returns current index, error and active index to 0.
- R2: When the current index equals the posted limit (pointer register, in descriptor units, exclusive), the state reads 2 (idle). No descriptor is read and rx_ready stays low. Raising the limit makes the channel resume.
- R3: A descriptor is read at ring base + 8 × index. Bits [12:0] of its control word give the buffer size in bytes, and bit 29 requests an interrupt. Bit 28 marks the end of the table: the index after that descriptor is 0 rather than index + 1.
- R4: The first payload byte of a frame goes to first buffer address + 4 + offset, where offset is control bits [7:1]. Later bytes go to consecutive addresses.
- R5: When a buffer fills before the frame ends, the channel fetches the next descriptor. Payload then continues at that descriptor's buffer address.
- R6: After the last byte of a frame, four byte writes go to the first buffer address, at offsets 0..3. They carry the header word {flags, length} little-endian. Length is the count of stored payload bytes. Header bit 23 flags an overflow, and header bits [27:24] hold the number of descriptors used minus one.
- R7: After the header, the current index points past the last descriptor the frame used. irq pulses for exactly one cycle if any descriptor of that frame had bit 29 set.
- R8: With control bit 10 set, a frame that needs a descriptor at the posted limit keeps the bytes already stored. Its remaining input bytes are accepted and discarded, its header gets the overflow flag, and reception continues.
- R9: With control bit 10 clear, that situation stops the channel: state 3, error 2, and no header is written.
- R10: A bus error on any buffer or header write stops the channel with error 3. No further writes are issued.
- R11: A failed descriptor read stops the channel with error 4.
- R12: A first descriptor smaller than offset + 5 bytes, or a later descriptor of size 0, stops the channel with error 1 before any payload is written.
- R13: Register select 0 is control, 1 is ring base (bits [11:0] read as 0), 2 is the posted limit and 3 is status. Status holds current index in [11:0], state in [15:12] (0 off, 1 active, 2 idle, 3 stopped), error in [19:16] and the active frame's first descriptor in [31:20]. A non-zero error occurs only in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rsel | input | 2 | Register select for reads |
| reg_rdata | output | 32 | Register read data |
| desc_rd_req | output | 1 | Descriptor read request |
| desc_rd_addr | output | 32 | Descriptor address |
| desc_rd_valid | input | 1 | Descriptor read response valid |
| desc_rd_ctrl | input | 32 | Descriptor control word |
| desc_rd_buf | input | 32 | Descriptor buffer address |
| desc_rd_err | input | 1 | Descriptor read failed |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Byte ends the frame |
| rx_ready | output | 1 | Channel accepts a byte |
| mem_wr_en | output | 1 | Memory byte write |
| mem_wr_addr | output | 32 | Memory write address |
| mem_wr_data | output | 8 | Memory write byte |
| mem_wr_err | input | 1 | Same-cycle bus error on the write |
| irq | output | 1 | Frame completion pulse |

## Verification
The hardest case to reach is a frame that runs out of ring partway through. It needs a wrapped ring, a limit just short of the frame's needs, and a frame long enough to cross two buffers. The bench gets there by chaining frames. Each frame leaves the current index where the next test needs it, and the limit is then moved to sit one or two descriptors ahead. The same setup runs twice, once with overflow-continue set and once with it clear. This shows both the truncated header and the halt with no header. Bus-error and bad-descriptor cases are reached by disabling, which rewinds the index to 0, and then aiming the fault at descriptor 0.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    localparam int ADDR_W    = 32;
    localparam int HDR_BYTES = 4;
    localparam int CTL_EN    = 0;
    localparam int CTL_OFF   = 1;
    localparam int CTL_OFF_W = 7;
    localparam int CTL_OC    = 10;
    localparam int D_EOT     = 28;
    localparam int D_IOC     = 29;

    typedef enum logic [2:0] {
        ST_OFF, ST_IDLE, ST_FETCH, ST_RECV, ST_DROP, ST_HDR, ST_STOP
    } rx_st_e;

    localparam logic [3:0] ERR_NONE  = 4'd0;
    localparam logic [3:0] ERR_PROTO = 4'd1;
    localparam logic [3:0] ERR_OVFL  = 4'd2;
    localparam logic [3:0] ERR_WBUS  = 4'd3;
    localparam logic [3:0] ERR_DBUS  = 4'd4;

    function automatic logic [3:0] st_code(rx_st_e s);
        case (s)
            ST_OFF:  return 4'd0;
            ST_IDLE: return 4'd2;
            ST_STOP: return 4'd3;
            default: return 4'd1;
        endcase
    endfunction
endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
    import rxring_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [31:0]      wdata,
    input  logic [1:0]       rsel,
    input  logic [31:0]      status,
    output logic [31:0]      rdata,
    output logic [31:0]      ctrl,
    output logic [31:0]      base,
    output logic [IDX_W-1:0] limit
);
    typedef struct packed {
        logic [31:0]      ctrl;
        logic [31:0]      base;
        logic [IDX_W-1:0] limit;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr) begin
            case (sel)
                2'd0:    d.ctrl  = wdata;
                2'd1:    d.base  = {wdata[31:12], 12'h000};
                2'd2:    d.limit = wdata[IDX_W-1:0];
                default: d = q;
            endcase
        end
        case (rsel)
            2'd0:    rdata = q.ctrl;
            2'd1:    rdata = q.base;
            2'd2:    rdata = 32'(q.limit);
            default: rdata = status;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl  = q.ctrl;
    assign base  = q.base;
    assign limit = q.limit;

    assert_base_aligned_R13: assert property (@(posedge clk) disable iff (!rst_n)
        base[11:0] == 12'h000);
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
    import rxring_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int BC_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              oc,
    input  logic [CTL_OFF_W-1:0] offset,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              desc_rd_req,
    output logic [ADDR_W-1:0] desc_rd_addr,
    input  logic              desc_rd_valid,
    input  logic [31:0]       desc_rd_ctrl,
    input  logic [ADDR_W-1:0] desc_rd_buf,
    input  logic              desc_rd_err,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    input  logic              mem_wr_err,
    output logic              irq,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [IDX_W-1:0]  act_idx,
    output logic [3:0]        state_code,
    output logic [3:0]        err_code
);
    typedef struct packed {
        rx_st_e            st;
        logic [IDX_W-1:0]  cur;
        logic [IDX_W-1:0]  first;
        logic              eot;
        logic              ioc;
        logic              ovf;
        logic              adv;
        logic              firstf;
        logic              irq;
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] haddr;
        logic [BC_W-1:0]   room;
        logic [15:0]       len;
        logic [3:0]        ndesc;
        logic [1:0]        hcnt;
        logic [3:0]        err;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_OFF, default: '0};

    eng_t q, d;
    logic [BC_W-1:0]  bc;
    logic [BC_W-1:0]  need;
    logic [IDX_W-1:0] nxt;
    logic [31:0]      hdr;
    logic             unused_bits;

    assign unused_bits = ^{desc_rd_ctrl[31:30], desc_rd_ctrl[27:BC_W]};

    always_comb begin
        d           = q;
        d.irq       = 1'b0;
        desc_rd_req = 1'b0;
        rx_ready    = 1'b0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = q.wptr;
        mem_wr_data = rx_data;
        bc   = desc_rd_ctrl[BC_W-1:0];
        need = BC_W'(offset) + BC_W'(HDR_BYTES + 1);
        nxt  = q.eot ? '0 : q.cur + 1'b1;
        hdr  = {4'b0000, q.ndesc, q.ovf, 7'b0000000, q.len};
        if (!en) begin
            d = ENG_RST;
        end else begin
            case (q.st)
                ST_OFF: begin
                    d.st     = ST_IDLE;
                    d.firstf = 1'b1;
                end
                ST_IDLE: begin
                    if (q.cur != last_idx) d.st = ST_FETCH;
                end
                ST_FETCH: begin
                    desc_rd_req = 1'b1;
                    if (desc_rd_valid) begin
                        if (desc_rd_err) begin
                            d.st  = ST_STOP;
                            d.err = ERR_DBUS;
                        end else if (q.firstf) begin
                            if (bc < need) begin
                                d.st  = ST_STOP;
                                d.err = ERR_PROTO;
                            end else begin
                                d.first  = q.cur;
                                d.haddr  = desc_rd_buf;
                                d.wptr   = desc_rd_buf + ADDR_W'(offset) + ADDR_W'(HDR_BYTES);
                                d.room   = bc - need + 1'b1;
                                d.len    = '0;
                                d.ndesc  = '0;
                                d.ovf    = 1'b0;
                                d.ioc    = desc_rd_ctrl[D_IOC];
                                d.eot    = desc_rd_ctrl[D_EOT];
                                d.firstf = 1'b0;
                                d.st     = ST_RECV;
                            end
                        end else if (bc == '0) begin
                            d.st  = ST_STOP;
                            d.err = ERR_PROTO;
                        end else begin
                            d.wptr  = desc_rd_buf;
                            d.room  = bc;
                            d.ndesc = q.ndesc + 1'b1;
                            d.ioc   = q.ioc | desc_rd_ctrl[D_IOC];
                            d.eot   = desc_rd_ctrl[D_EOT];
                            d.st    = ST_RECV;
                        end
                    end
                end
                ST_RECV: begin
                    rx_ready  = 1'b1;
                    mem_wr_en = rx_valid;
                    if (rx_valid) begin
                        if (mem_wr_err) begin
                            d.st  = ST_STOP;
                            d.err = ERR_WBUS;
                        end else begin
                            d.wptr = q.wptr + 1'b1;
                            d.room = q.room - 1'b1;
                            d.len  = q.len + 1'b1;
                            if (rx_last) begin
                                d.st   = ST_HDR;
                                d.hcnt = 2'd0;
                                d.adv  = 1'b1;
                            end else if (q.room == BC_W'(1)) begin
                                d.cur = nxt;
                                if (nxt == last_idx) begin
                                    if (oc) begin
                                        d.st  = ST_DROP;
                                        d.ovf = 1'b1;
                                        d.adv = 1'b0;
                                    end else begin
                                        d.st  = ST_STOP;
                                        d.err = ERR_OVFL;
                                    end
                                end else begin
                                    d.st = ST_FETCH;
                                end
                            end
                        end
                    end
                end
                ST_DROP: begin
                    rx_ready = 1'b1;
                    if (rx_valid && rx_last) begin
                        d.st   = ST_HDR;
                        d.hcnt = 2'd0;
                    end
                end
                ST_HDR: begin
                    mem_wr_en   = 1'b1;
                    mem_wr_addr = q.haddr + ADDR_W'(q.hcnt);
                    mem_wr_data = hdr[{q.hcnt, 3'b000} +: 8];
                    if (mem_wr_err) begin
                        d.st  = ST_STOP;
                        d.err = ERR_WBUS;
                    end else begin
                        d.hcnt = q.hcnt + 1'b1;
                        if (q.hcnt == 2'd3) begin
                            d.irq    = q.ioc;
                            d.firstf = 1'b1;
                            if (q.adv) begin
                                d.cur = nxt;
                                d.st  = (nxt == last_idx) ? ST_IDLE : ST_FETCH;
                            end else begin
                                d.st  = (q.cur == last_idx) ? ST_IDLE : ST_FETCH;
                            end
                        end
                    end
                end
                default: d = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    assign desc_rd_addr = ring_base + (ADDR_W'(q.cur) << 3);
    assign irq          = q.irq;
    assign cur_idx      = q.cur;
    assign act_idx      = q.first;
    assign state_code   = st_code(q.st);
    assign err_code     = q.err;

    assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_code == 4'd0 && err_code == ERR_NONE && cur_idx == '0));
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd2) |-> (!desc_rd_req && !rx_ready && !mem_wr_en));
    assert_desc_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_req |-> (desc_rd_addr[2:0] == 3'b000 && desc_rd_addr[31:12] == ring_base[31:12]));
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_bus_err_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mem_wr_en && mem_wr_err) |=> (!en || (state_code == 4'd3 && err_code == ERR_WBUS)));
    assert_err_only_stopped_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != ERR_NONE) |-> (state_code == 4'd3));
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
    import rxring_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int BC_W  = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  reg_rsel,
    output logic [31:0] reg_rdata,
    output logic        desc_rd_req,
    output logic [31:0] desc_rd_addr,
    input  logic        desc_rd_valid,
    input  logic [31:0] desc_rd_ctrl,
    input  logic [31:0] desc_rd_buf,
    input  logic        desc_rd_err,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic        mem_wr_en,
    output logic [31:0] mem_wr_addr,
    output logic [7:0]  mem_wr_data,
    input  logic        mem_wr_err,
    output logic        irq
);
    logic [31:0]      ctrl, base, status;
    logic [IDX_W-1:0] limit, cur_idx, act_idx;
    logic [3:0]       state_code, err_code;
    logic             unused_ctrl;

    assign unused_ctrl = ^{ctrl[31:11], ctrl[9:8]};
    assign status = {12'(act_idx), err_code, state_code, 12'(cur_idx)};

    rxring_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .rsel(reg_rsel), .status(status), .rdata(reg_rdata),
        .ctrl(ctrl), .base(base), .limit(limit)
    );

    rxring_engine #(.IDX_W(IDX_W), .BC_W(BC_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl[CTL_EN]), .oc(ctrl[CTL_OC]), .offset(ctrl[CTL_OFF +: CTL_OFF_W]),
        .ring_base(base), .last_idx(limit),
        .desc_rd_req(desc_rd_req), .desc_rd_addr(desc_rd_addr),
        .desc_rd_valid(desc_rd_valid), .desc_rd_ctrl(desc_rd_ctrl),
        .desc_rd_buf(desc_rd_buf), .desc_rd_err(desc_rd_err),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_err(mem_wr_err), .irq(irq),
        .cur_idx(cur_idx), .act_idx(act_idx), .state_code(state_code), .err_code(err_code)
    );
endmodule

// File: tb/rxring_dma_test.sv
module rxring_dma_test;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0, reg_rsel = 2'd3;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic desc_rd_req, desc_rd_valid = 1'b0, desc_rd_err = 1'b0;
    logic [31:0] desc_rd_addr, desc_rd_ctrl = '0, desc_rd_buf = '0;
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
    logic [7:0] rx_data = '0;
    logic mem_wr_en, mem_wr_err, irq;
    logic [31:0] mem_wr_addr;
    logic [7:0] mem_wr_data;

    logic [31:0] bad_addr = 32'hFFFF_FFFF;
    logic desc_err_on = 1'b0;
    int dbc[8];
    logic [31:0] dbuf[8];
    bit deot[8], dioc[8];

    int vectors = 0, fails = 0, irq_seen = 0, exp_irq = 0;
    logic [31:0] qa[$];
    logic [7:0] qd[$];
    int mcur = 0, mlast = 0, moff = 0;
    bit moc = 0;

    assign mem_wr_err = mem_wr_en && (mem_wr_addr == bad_addr);

    rxring_dma uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // descriptor responder
    always @(negedge clk) begin
        int i;
        i = int'((desc_rd_addr - BASE) >> 3) & 7;
        desc_rd_valid = desc_rd_req;
        desc_rd_err   = desc_err_on;
        desc_rd_ctrl  = (32'(dioc[i]) << 29) | (32'(deot[i]) << 28) | 32'(dbc[i]);
        desc_rd_buf   = dbuf[i];
    end

    // every-clock write stream compare
    always @(negedge clk) begin
        #4;
        if (mem_wr_en) begin
            if (qa.size() == 0) begin
                chk(1'b0, "R4/R6 unexpected write", mem_wr_addr, 32'hX);
            end else begin
                logic [31:0] ea;
                logic [7:0] ed;
                ea = qa.pop_front();
                ed = qd.pop_front();
                chk(mem_wr_addr == ea && mem_wr_data == ed, "R4/R5/R6 write",
                    {mem_wr_data, mem_wr_addr[23:0]}, {ed, ea[23:0]});
            end
        end
        if (irq) irq_seen++;
    end

    task automatic wreg(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rstat(output logic [31:0] v);
        @(negedge clk);
        reg_rsel = 2'd3;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] stat(int cd, int st, int er, int ad);
        return {12'(ad), 4'(er), 4'(st), 12'(cd)};
    endfunction

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 7 + k) & 255);
    endfunction

    // behavioural expectation for one frame
    task automatic model_frame(input int n, input int seed);
        int first, room, stored, nd, k, nx;
        bit ovf, stop, drop, ioc_any;
        logic [31:0] addr, hw;
        first = mcur; room = dbc[mcur] - 4 - moff; addr = dbuf[mcur] + 32'(4 + moff);
        stored = 0; nd = 0; ovf = 0; stop = 0; drop = 0; ioc_any = dioc[mcur];
        for (k = 0; k < n; k++) begin
            if (drop) continue;
            qa.push_back(addr); qd.push_back(pat(seed, k));
            addr++; room--; stored++;
            if (k == n - 1) break;
            if (room == 0) begin
                nx = deot[mcur] ? 0 : mcur + 1;
                mcur = nx;
                if (nx == mlast) begin
                    if (moc) begin ovf = 1; drop = 1; end
                    else begin stop = 1; break; end
                end else begin
                    nd++; room = dbc[mcur]; addr = dbuf[mcur]; ioc_any |= dioc[mcur];
                end
            end
        end
        if (!stop) begin
            hw = {4'h0, 4'(nd), ovf, 7'h0, 16'(stored)};
            for (int b = 0; b < 4; b++) begin
                qa.push_back(dbuf[first] + 32'(b)); qd.push_back(hw[8*b +: 8]);
            end
            if (!drop) mcur = deot[mcur] ? 0 : mcur + 1;
            if (ioc_any) exp_irq++;
        end
    endtask

    task automatic send_frame(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            int w;
            @(negedge clk);
            rx_valid = 1'b1; rx_data = pat(seed, k); rx_last = (k == n - 1);
            w = 0;
            while (!rx_ready && w < 40) begin @(negedge clk); w++; end
            if (!rx_ready) break;
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic set_ctrl(input bit en, input int off, input bit oc);
        moff = off; moc = oc;
        if (!en) mcur = 0;
        wreg(2'd0, (32'(oc) << 10) | (32'(off) << 1) | 32'(en));
    endtask

    task automatic set_limit(input int l);
        mlast = l;
        wreg(2'd2, 32'(l));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", vectors);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] s;
        for (int i = 0; i < 8; i++) begin
            dbc[i] = 64; dbuf[i] = 32'h2000 + 32'(i) * 32'h100; deot[i] = (i == 7); dioc[i] = (i == 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rstat(s); chk(s == 0, "R1 reset status", s, 0);
        chk(!rx_ready && !desc_rd_req, "R1 reset outputs", {rx_ready, desc_rd_req}, 0);
        wreg(2'd1, BASE | 32'hABC);
        @(negedge clk); reg_rsel = 2'd1; #1;
        chk(reg_rdata == BASE, "R13 base low bits", reg_rdata, BASE);
        // R2 idle with nothing posted
        set_limit(0); set_ctrl(1, 2, 0);
        repeat (5) @(negedge clk);
        rstat(s); chk(s == stat(0, 2, 0, 0), "R2 idle", s, stat(0, 2, 0, 0));
        chk(!rx_ready && !desc_rd_req, "R2 quiet", {rx_ready, desc_rd_req}, 0);
        // R4 single-buffer frame after posting
        set_limit(4);
        model_frame(20, 1); send_frame(20, 1);
        rstat(s); chk(s == stat(1, 1, 0, 1), "R2/R4 resume", s, stat(1, 1, 0, 1));
        // R5/R6/R7 scatter over three buffers, irq from descriptor 3
        model_frame(150, 2); send_frame(150, 2);
        rstat(s); chk(s == stat(4, 2, 0, 1), "R5/R7 scatter end", s, stat(4, 2, 0, 1));
        chk(irq_seen == exp_irq && exp_irq == 1, "R7 irq count", 32'(irq_seen), 32'(exp_irq));
        // R3 wrap through end-of-table
        set_limit(2);
        model_frame(200, 3); send_frame(200, 3);
        rstat(s); chk(s == stat(0, 1, 0, 0), "R3 wrap", s, stat(0, 1, 0, 0));
        // R8 overflow continue
        set_ctrl(1, 2, 1);
        model_frame(130, 4); send_frame(130, 4);
        rstat(s); chk(s == stat(2, 2, 0, 0), "R8 overflow continue", s, stat(2, 2, 0, 0));
        chk(irq_seen == 1, "R7 no irq without flag", 32'(irq_seen), 1);
        // R9 overflow halt
        set_ctrl(1, 2, 0); set_limit(4);
        model_frame(200, 5); send_frame(200, 5);
        rstat(s); chk(s == stat(4, 3, 2, 2), "R9 overflow stop", s, stat(4, 3, 2, 2));
        chk(irq_seen == 1, "R9 no irq on halt", 32'(irq_seen), 1);
        // R1 disable clears
        set_ctrl(0, 0, 0);
        rstat(s); chk(s == 0, "R1 disable clears", s, 0);
        // R10 bus error on first payload byte
        set_limit(3); bad_addr = dbuf[0] + 4;
        qa.push_back(dbuf[0] + 4); qd.push_back(pat(6, 0));
        set_ctrl(1, 0, 0); send_frame(5, 6);
        rstat(s); chk(s == stat(0, 3, 3, 0), "R10 write bus error", s, stat(0, 3, 3, 0));
        bad_addr = 32'hFFFF_FFFF;
        set_ctrl(0, 0, 0);
        // R12 undersized first descriptor
        dbc[0] = 4;
        set_ctrl(1, 0, 0); repeat (10) @(negedge clk);
        rstat(s); chk(s == stat(0, 3, 1, 0), "R12 protocol error", s, stat(0, 3, 1, 0));
        chk(qa.size() == 0, "R12 no writes", 32'(qa.size()), 0);
        dbc[0] = 64; set_ctrl(0, 0, 0);
        // R11 descriptor read error
        desc_err_on = 1'b1;
        set_ctrl(1, 0, 0); repeat (10) @(negedge clk);
        rstat(s); chk(s == stat(0, 3, 4, 0), "R11 descriptor error", s, stat(0, 3, 4, 0));
        desc_err_on = 1'b0; set_ctrl(0, 0, 0);
        // R4 zero offset
        set_ctrl(1, 0, 0);
        model_frame(7, 8); send_frame(7, 8);
        rstat(s); chk(s == stat(1, 1, 0, 1), "R4 zero offset", s, stat(1, 1, 0, 1));
        chk(qa.size() == 0, "R6 all writes seen", 32'(qa.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule